// File: doc/BRIEF.md
# Fracturable Hybrid Logic Element

This block models one basic logic element of a programmable fabric. It holds two 6-input lookup tables. The first table always computes a single 6-input function of its own inputs. The second table can compute one 6-input function, or it can be split into smaller sub-tables. A parameter fixes how it splits: two 5-input tables, one 5-input table with two 4-input tables, or four 4-input tables. The sub-tables share the low address lines. Each 5-input sub-table takes its extra address bit from a dedicated top-select port.

Each logic output can be taken straight from the tables or from a flip-flop that captured it. A separate flip-flop path carries an external bit into a register without passing through any table. In adder mode, two sub-tables supply the propagate and generate terms of one bit of a ripple-carry chain. The element then drives a sum and an explicit carry-out, so that neighbouring elements can be chained. All table contents and mode bits come from a serial configuration chain, which is shifted while a load enable is high.

Top module: `frac_logic_elem`

## Requirements
- R1: The configuration is a 135-bit register shifted one bit per clock while `cfg_en` is high, with the new bit entering at bit 0, so the first bit loaded ends in bit 134. `cfg_dout` always shows bit 134. The register holds when `cfg_en` is low, and reset does not alter it. Bit layout: [63:0] fixed table, [127:64] divisible table, [132:128] output register selects, [133] adder enable, [134] split enable.
- R2: `y_fix` (when not registered) equals fixed-table bit number `a_in`.
- R3: With split and adder enables both low, `y_sub[0]` equals divisible-table bit number `b_in`, and `y_sub[3:1]` are zero.
- R4: With FRAC_N=2 and the table split, `y_sub[0]` is table bit {top_sel[0], b_in[3:0]} and `y_sub[1]` is bit 32+{top_sel[1], b_in[3:0]}. `y_sub[3:2]` are zero.
- R5: With FRAC_N=3 and the table split, `y_sub[0]` is table bit {top_sel[0], b_in[3:0]}, `y_sub[1]` is bit 32+b_in[3:0], `y_sub[2]` is bit 48+b_in[3:0], and `y_sub[3]` is zero.
- R6: With FRAC_N=4 and the table split, `y_sub[k]` is table bit 16*k+b_in[3:0] for k = 0..3.
- R7: With the adder enable high, the table is split regardless of bit 134. Taking p as sub-table 0 and g as sub-table 1, `y_sub[0]` becomes p XOR `cin` and `cout` is `cin` when p=1, else g. With the adder enable low, `cout` is 0.
- R8: Register select bit 128 governs `y_fix`, and bits 129..132 govern `y_sub[0..3]`. A set bit makes the output show a flip-flop that loads the combinational value on a rising edge with `ce` high. A clear bit shows the combinational value.
- R9: While `ce` is low, every flip-flop (logic outputs and bypass) holds its value.
- R10: A rising edge with `rst_n` low clears every flip-flop to 0, whatever `ce` is.
- R11: `y_byp` is a flip-flop that loads `byp_in` on a rising edge with `ce` high, with no table in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the output flip-flops |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out (bit 134) |
| ce | input | 1 | Clock enable of all output flip-flops |
| a_in | input | 6 | Address of the fixed table |
| b_in | input | 6 | Shared address of the divisible table |
| top_sel | input | 2 | Extra top address bits of the 5-input sub-tables |
| cin | input | 1 | Carry in |
| byp_in | input | 1 | Data for the register bypass path |
| y_fix | output | 1 | Fixed-table output |
| y_sub | output | 4 | Divisible-table outputs |
| y_byp | output | 1 | Bypass register output |
| cout | output | 1 | Carry out |

## Verification
Inputs change half a period before a rising edge. Every output is sampled a quarter period after that edge, and the scoreboard item pushed with the stimulus holds the values due at that point. Combinational outputs and `cout` reflect the held inputs with the configuration as updated by that same edge. Registered outputs and `y_byp` reflect what was captured at that edge, and `cfg_dout` shows a bit loaded 135 shifts earlier. Every fracture mode is covered by three instances with FRAC_N of 2, 3 and 4, driven by the same stimulus and compared against one reference model.

// File: rtl/fle_pkg.sv
// Package fle_pkg
// Shared sizes and the configuration layout of the fracturable logic element.
// Assumes 6-input tables and at most four sub-tables.
package fle_pkg;
    localparam int LUT_K  = 6;
    localparam int TBL_W  = 1 << LUT_K;
    localparam int SUB_W  = 4;
    localparam int NOUT   = 1 + SUB_W;
    localparam int TOP_W  = 2;
    localparam int MODE_W = NOUT + 2;
    localparam int CFG_W  = 2 * TBL_W + MODE_W;

    typedef struct packed {
        logic            split_en;
        logic            add_en;
        logic [NOUT-1:0] reg_sel;
    } mode_t;

    typedef struct packed {
        mode_t            mode;
        logic [TBL_W-1:0] div_tbl;
        logic [TBL_W-1:0] fix_tbl;
    } cfg_t;
endpackage

// File: rtl/fle_cfg_chain.sv
// Module fle_cfg_chain
// Serial configuration register. It shifts toward the MSB while enabled.
// Assumes the content is not touched by reset: it is loaded before use.
module fle_cfg_chain #(
    parameter int W = 135
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic         cfg_din,
    output logic [W-1:0] cfg_q,
    output logic         cfg_dout
);
    // Shift one configuration bit in per enabled clock
    always_ff @(posedge clk) begin
        if (cfg_en) begin
            cfg_q <= {cfg_q[W-2:0], cfg_din};
        end
    end

    assign cfg_dout = cfg_q[W-1];

    // R1
    cfg_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (cfg_q[0] == $past(cfg_din)));
    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_q));
endmodule

// File: rtl/fle_lut.sv
// Module fle_lut
// Plain K-input lookup table: the address picks one bit of the table.
// Assumes the table content is static while the address is in use.
module fle_lut #(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] tbl,
    input  logic [K-1:0]      addr,
    output logic              y
);
    assign y = tbl[addr];
endmodule

// File: rtl/fle_frac_table.sv
// Module fle_frac_table
// Divisible 6-input table. Unsplit, it gives one 6-input function on y[0].
// Split, it gives FRAC_N sub-tables sharing the low four address bits.
// A 5-input sub-table takes its top address bit from top_sel.
// Assumes FRAC_N is 2, 3 or 4. Outputs with no sub-table are driven to zero.
module fle_frac_table
    import fle_pkg::*;
#(
    parameter int FRAC_N = 3
) (
    input  logic [TBL_W-1:0] tbl,
    input  logic [LUT_K-1:0] sel,
    input  logic [TOP_W-1:0] top_sel,
    input  logic             split,
    output logic [SUB_W-1:0] y
);
    localparam int HALF  = TBL_W / 2;
    localparam int QUART = TBL_W / 4;
    localparam int LOW_K = LUT_K - 2;

    logic             whole_y;
    logic [SUB_W-1:0] frac_y;

    fle_lut #(.K(LUT_K)) u_whole (
        .tbl  (tbl),
        .addr (sel),
        .y    (whole_y)
    );

    generate
        if (FRAC_N == 2) begin : g_n2
            for (genvar k = 0; k < 2; k++) begin : g_half
                fle_lut #(.K(LUT_K-1)) u_sub (
                    .tbl  (tbl[k*HALF +: HALF]),
                    .addr ({top_sel[k], sel[LOW_K-1:0]}),
                    .y    (frac_y[k])
                );
            end
            assign frac_y[SUB_W-1:2] = '0;
        end else if (FRAC_N == 3) begin : g_n3
            logic unused_top;
            fle_lut #(.K(LUT_K-1)) u_big (
                .tbl  (tbl[0 +: HALF]),
                .addr ({top_sel[0], sel[LOW_K-1:0]}),
                .y    (frac_y[0])
            );
            for (genvar k = 0; k < 2; k++) begin : g_small
                fle_lut #(.K(LOW_K)) u_sub (
                    .tbl  (tbl[HALF + k*QUART +: QUART]),
                    .addr (sel[LOW_K-1:0]),
                    .y    (frac_y[1+k])
                );
            end
            assign frac_y[SUB_W-1] = 1'b0;
            assign unused_top      = top_sel[1];
        end else begin : g_n4
            logic unused_top;
            for (genvar k = 0; k < SUB_W; k++) begin : g_quart
                fle_lut #(.K(LOW_K)) u_sub (
                    .tbl  (tbl[k*QUART +: QUART]),
                    .addr (sel[LOW_K-1:0]),
                    .y    (frac_y[k])
                );
            end
            assign unused_top = ^top_sel;
        end
    endgenerate

    // Pick the split outputs or the single 6-input result
    always_comb begin
        y = split ? frac_y : {{(SUB_W-1){1'b0}}, whole_y};
    end
endmodule

// File: rtl/fle_out_stage.sv
// Module fle_out_stage
// One flip-flop per logic output plus a bypass flip-flop. All share a clock
// enable and a synchronous active-low reset. A select bit per output chooses
// the registered or the combinational value.
// Assumes d is settled before each rising edge.
module fle_out_stage #(
    parameter int NOUT = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce,
    input  logic [NOUT-1:0] d,
    input  logic [NOUT-1:0] sel,
    input  logic            byp_d,
    output logic [NOUT-1:0] y,
    output logic            byp_q
);
    logic [NOUT-1:0] q_r;

    // Capture logic results and the bypass bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r   <= '0;
            byp_q <= 1'b0;
        end else if (ce) begin
            q_r   <= d;
            byp_q <= byp_d;
        end
    end

    generate
        for (genvar i = 0; i < NOUT; i++) begin : g_mux
            assign y[i] = sel[i] ? q_r[i] : d[i];
        end
    endgenerate

    // R10
    reg_clear_chk: assert property (@(posedge clk)
        !rst_n |=> ((q_r == '0) && !byp_q));
    // R9
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !ce) |=> ($stable(q_r) && $stable(byp_q)));
    // R8
    reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && ce) |=> (q_r == $past(d)));
    // R11
    byp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && ce) |=> (byp_q == $past(byp_d)));
endmodule

// File: rtl/frac_logic_elem.sv
// Module frac_logic_elem
// Hybrid logic element: a fixed 6-input table, a divisible 6-input table
// (split pattern chosen by FRAC_N), one ripple-carry bit, output flip-flops
// and a register bypass. All contents come from a serial configuration chain.
// Assumes the chain is loaded before outputs are used.
module frac_logic_elem
    import fle_pkg::*;
#(
    parameter int FRAC_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_din,
    output logic             cfg_dout,
    input  logic             ce,
    input  logic [LUT_K-1:0] a_in,
    input  logic [LUT_K-1:0] b_in,
    input  logic [TOP_W-1:0] top_sel,
    input  logic             cin,
    input  logic             byp_in,
    output logic             y_fix,
    output logic [SUB_W-1:0] y_sub,
    output logic             y_byp,
    output logic             cout
);
    logic [CFG_W-1:0] cfg_bits;
    cfg_t             cfg;
    logic             fix_raw;
    logic             split;
    logic [SUB_W-1:0] sub_raw;
    logic [SUB_W-1:0] sub_fin;
    logic [NOUT-1:0]  out_y;

    fle_cfg_chain #(.W(CFG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .cfg_q    (cfg_bits),
        .cfg_dout (cfg_dout)
    );

    assign cfg   = cfg_t'(cfg_bits);
    assign split = cfg.mode.split_en | cfg.mode.add_en;

    fle_lut #(.K(LUT_K)) u_fix (
        .tbl  (cfg.fix_tbl),
        .addr (a_in),
        .y    (fix_raw)
    );

    fle_frac_table #(.FRAC_N(FRAC_N)) u_div (
        .tbl     (cfg.div_tbl),
        .sel     (b_in),
        .top_sel (top_sel),
        .split   (split),
        .y       (sub_raw)
    );

    // Adder bit: sub-table 0 is propagate, sub-table 1 is generate
    always_comb begin
        sub_fin = sub_raw;
        cout    = 1'b0;
        if (cfg.mode.add_en) begin
            sub_fin[0] = sub_raw[0] ^ cin;
            cout       = sub_raw[0] ? cin : sub_raw[1];
        end
    end

    fle_out_stage #(.NOUT(NOUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .d     ({sub_fin, fix_raw}),
        .sel   (cfg.mode.reg_sel),
        .byp_d (byp_in),
        .y     (out_y),
        .byp_q (y_byp)
    );

    assign y_fix = out_y[0];
    assign y_sub = out_y[NOUT-1:1];

    // R7
    carry_prop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode.add_en && sub_raw[0]) |-> (cout == cin));
    // R7
    carry_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.mode.add_en |-> !cout);
    // R3
    whole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !split |-> (sub_raw[SUB_W-1:1] == '0));
endmodule

// File: tb/test_frac_logic_elem.sv
// Bench for frac_logic_elem: three instances (FRAC_N 2, 3, 4) share one
// stimulus. A driver task pushes expected values from a reference model,
// and a monitor pops and compares them a quarter period after each edge.
module test_frac_logic_elem;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 135;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic       ce = 1'b0;
    logic [5:0] a_in = '0;
    logic [5:0] b_in = '0;
    logic [1:0] top_sel = '0;
    logic       cin = 1'b0;
    logic       byp_in = 1'b0;

    logic       y_fix_w  [3];
    logic [3:0] y_sub_w  [3];
    logic       y_byp_w  [3];
    logic       cout_w   [3];
    logic       dout_w   [3];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    generate
        for (genvar gi = 0; gi < 3; gi++) begin : g_dut
            frac_logic_elem #(.FRAC_N(gi+2)) i_frac_logic_elem (
                .clk      (clk),
                .rst_n    (rst_n),
                .cfg_en   (cfg_en),
                .cfg_din  (cfg_din),
                .cfg_dout (dout_w[gi]),
                .ce       (ce),
                .a_in     (a_in),
                .b_in     (b_in),
                .top_sel  (top_sel),
                .cin      (cin),
                .byp_in   (byp_in),
                .y_fix    (y_fix_w[gi]),
                .y_sub    (y_sub_w[gi]),
                .y_byp    (y_byp_w[gi]),
                .cout     (cout_w[gi])
            );
        end
    endgenerate

    typedef struct packed {
        logic [2:0]      fix;
        logic [2:0][3:0] sub;
        logic [2:0]      co;
        logic            byp;
        logic            dout;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    logic [CW-1:0] m_cfg = '0;
    logic [4:0]    m_q [3] = '{default: '0};
    logic          m_byp = 1'b0;

    string frac_tag [3] = '{"R4", "R5", "R6"};

    // Sub-table outputs from the requirement text
    function automatic logic [3:0] ref_sub(int n, logic [63:0] d, logic [5:0] b,
                                           logic [1:0] s, logic split);
        logic [3:0] r = '0;
        if (!split) begin
            r[0] = d[b];
        end else if (n == 2) begin
            r[0] = d[{s[0], b[3:0]}];
            r[1] = d[32 + {s[1], b[3:0]}];
        end else if (n == 3) begin
            r[0] = d[{s[0], b[3:0]}];
            r[1] = d[32 + b[3:0]];
            r[2] = d[48 + b[3:0]];
        end else begin
            for (int k = 0; k < 4; k++) r[k] = d[16*k + b[3:0]];
        end
        return r;
    endfunction

    // Returns {cout, sub[3:0], fix}
    function automatic logic [5:0] ref_comb(int n, logic [CW-1:0] c, logic [5:0] a,
                                            logic [5:0] b, logic [1:0] s, logic ci);
        logic [3:0] sb;
        logic       co = 1'b0;
        sb = ref_sub(n, c[127:64], b, s, c[134] | c[133]);
        if (c[133]) begin
            co    = sb[0] ? ci : sb[1];
            sb[0] = sb[0] ^ ci;
        end
        return {co, sb, c[a]};
    endfunction

    // Driver: apply one cycle of stimulus and queue what is due after the edge
    task automatic step(input string tag, input logic rst_v, input logic en_v,
                        input logic din_v, input logic ce_v);
        logic [5:0] pre [3];
        logic [5:0] post;
        exp_t       e;
        @(negedge clk);
        rst_n   = rst_v;
        cfg_en  = en_v;
        cfg_din = en_v ? din_v : 1'($urandom());
        ce      = ce_v;
        a_in    = 6'($urandom());
        b_in    = 6'($urandom());
        top_sel = 2'($urandom());
        cin     = 1'($urandom());
        byp_in  = 1'($urandom());
        for (int i = 0; i < 3; i++) pre[i] = ref_comb(i+2, m_cfg, a_in, b_in, top_sel, cin);
        if (!rst_v) begin
            for (int i = 0; i < 3; i++) m_q[i] = '0;
            m_byp = 1'b0;
        end else if (ce_v) begin
            for (int i = 0; i < 3; i++) m_q[i] = pre[i][4:0];
            m_byp = byp_in;
        end
        if (en_v) m_cfg = {m_cfg[CW-2:0], din_v};
        for (int i = 0; i < 3; i++) begin
            post = ref_comb(i+2, m_cfg, a_in, b_in, top_sel, cin);
            e.fix[i] = m_cfg[128] ? m_q[i][0] : post[0];
            for (int k = 0; k < 4; k++)
                e.sub[i][k] = m_cfg[129+k] ? m_q[i][1+k] : post[1+k];
            e.co[i] = post[5];
        end
        e.byp  = m_byp;
        e.dout = m_cfg[CW-1];
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic load(input string tag, input logic rst_v, input logic [CW-1:0] v);
        for (int i = CW-1; i >= 0; i--) step(tag, rst_v, 1'b1, v[i], 1'b0);
    endtask

    function automatic logic [CW-1:0] make_cfg(logic sp, logic ad, logic [4:0] rs);
        return {sp, ad, rs, $urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic run(input string tag, input int n, input logic ce_v, input bit ce_rand);
        for (int i = 0; i < n; i++) step(tag, 1'b1, 1'b0, 1'b0, ce_rand ? 1'($urandom()) : ce_v);
    endtask

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compare outputs a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                bit    regp;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                regp = (t == "R8") || (t == "R9") || (t == "R10");
                if (t != "") begin
                    for (int i = 0; i < 3; i++) begin
                        chk(regp ? t : "R2", {3'b0, y_fix_w[i]}, {3'b0, e.fix[i]});
                        chk((t == "FRAC") ? frac_tag[i] : t, y_sub_w[i], e.sub[i]);
                        chk("R7", {3'b0, cout_w[i]}, {3'b0, e.co[i]});
                        chk((t == "R10") ? "R10" : "R11", {3'b0, y_byp_w[i]}, {3'b0, e.byp});
                        chk("R1", {3'b0, dout_w[i]}, {3'b0, e.dout});
                    end
                end
            end
        end
    end

    // Stimulus sequence
    initial begin
        // Fill the chain under reset; nothing is known until it is full
        load("", 1'b0, make_cfg(1'b1, 1'b0, 5'h1f));
        // R10: registered outputs and bypass read zero while reset is low
        for (int i = 0; i < 3; i++) step("R10", 1'b0, 1'b0, 1'b0, 1'b1);
        // R3: whole 6-input function
        load("R1", 1'b1, make_cfg(1'b0, 1'b0, 5'h00));
        run("R3", 50, 1'b1, 1'b1);
        // R4 R5 R6: fractured tables, two table sets
        load("R1", 1'b1, make_cfg(1'b1, 1'b0, 5'h00));
        run("FRAC", 60, 1'b1, 1'b1);
        load("R1", 1'b1, make_cfg(1'b1, 1'b0, 5'h00));
        run("FRAC", 60, 1'b1, 1'b1);
        // R7: adder mode without and with the split bit
        load("R1", 1'b1, make_cfg(1'b0, 1'b1, 5'h00));
        run("R7", 50, 1'b1, 1'b1);
        load("R1", 1'b1, make_cfg(1'b1, 1'b1, 5'h00));
        run("R7", 30, 1'b1, 1'b1);
        // R8: all outputs registered, then a mixed select pattern
        load("R1", 1'b1, make_cfg(1'b1, 1'b1, 5'h1f));
        run("R8", 40, 1'b1, 1'b0);
        // R9: enable low, inputs keep changing
        run("R9", 20, 1'b0, 1'b0);
        // R10: reset with registered outputs visible
        run("R8", 5, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) step("R10", 1'b0, 1'b0, 1'b0, 1'($urandom()));
        run("R8", 10, 1'b1, 1'b1);
        load("R1", 1'b1, make_cfg(1'b1, 1'b0, 5'h15));
        run("R8", 40, 1'b1, 1'b1);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (R1..R11 sequence incomplete): actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule